// File: doc/BRIEF.md
# Timer and Watchdog with a Shared Prescaler

This block holds an 8-bit count-up timer and an 8-bit watchdog counter that use one 8-bit programmable prescaler between them. A 6-bit mode register is written in one cycle from the core's working register. It picks four things:
- the timer's clock source, either the instruction-cycle enable or the external count pin;
- which edge of the pin counts;
- whether the prescaler sits in front of the timer or in front of the watchdog;
- the prescaler's division ratio.

The counter that does not own the prescaler runs undivided.

Software loads the timer through a write strobe. When the timer wraps, the block raises a one-cycle overflow pulse. The watchdog counts a free-running tick that comes from outside. A clear strobe restarts it, and an enable held at a fixed level switches it off for good. When the watchdog wraps, the block raises a one-cycle time-out request that the reset logic acts on. Every pin is a plain level or strobe, sampled on the rising clock edge. The block has no stream interface, so there is no back-pressure.

Top module: `tw_timer_wdt`

## Requirements
- R1: After reset the timer reads 0x00 and both output pulses are low. The mode register holds 6'b111111: falling pin edges, prescaler owned by the watchdog, ratio select 7. So right after reset the timer ignores `cyc_en` and rising pin edges, and it counts one per falling pin edge.
- R2: With the mode field layout {src[5], edge[4], owner[3], ratio[2:0]}, owner=1 and src=0, the timer adds one on every cycle that `cyc_en` is high.
- R3: With owner=0, the timer adds one on every 2^(ratio+1)-th source event after the prescaler was last cleared. This gives 1:2 for ratio=0 up to 1:256 for ratio=7.
- R4: With src=1, the timer counts rising pin edges when edge=0 and falling pin edges when edge=1. An edge is a change between two consecutive clock samples of `ext_pin`. Edges of the other polarity are ignored.
- R5: With src=0, edges on `ext_pin` are ignored. With src=1, `cyc_en` is ignored.
- R6: On an increment from 0xFF the timer becomes 0x00, and `cnt_ovf` is high for exactly the cycle in which it reads 0x00.
- R7: A timer write loads `cnt_wdata` on the next edge. It wins over an increment in the same cycle, and it clears the prescaler count.
- R8: `wdt_timeout` pulses for one cycle on the 256th watchdog event after a clear. With owner=1, a watchdog event is every 2^ratio-th tick. With owner=0, every tick is an event.
- R9: `wdt_clr` restarts the watchdog count. When the watchdog owns the prescaler, it clears the prescaler count too. No time-out appears in the cycle after a clear.
- R10: While `wdt_en` is low the watchdog holds its count and never raises `wdt_timeout`.
- R11: A mode write that changes the owner bit clears the prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable, the internal count source |
| ext_pin | input | 1 | External count pin, already synchronized |
| wdt_tick | input | 1 | Free-running watchdog tick, one cycle wide |
| wdt_en | input | 1 | Watchdog enable from a static configuration bit |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 6 | Mode value {src, edge, owner, ratio[2:0]} |
| cnt_we | input | 1 | Timer write strobe |
| cnt_wdata | input | 8 | Timer load value |
| wdt_clr | input | 1 | Watchdog clear strobe |
| cnt_q | output | 8 | Current timer value |
| cnt_ovf | output | 1 | One-cycle pulse when the timer wraps to 0x00 |
| wdt_timeout | output | 1 | One-cycle watchdog time-out request |

## Verification
The properties assume two things about the inputs. First, `wdt_en` only changes while no watchdog event is pending. Second, `ext_pin` arrives already synchronized and stays clean at clock granularity, so any two samples that differ count as one real edge. The stimulus meets both. It holds `ext_pin` low through reset, changes the pin at most once per cycle, and drives all strobes on the falling clock edge. It changes `wdt_en` only while `wdt_tick` is idle, and it keeps the watchdog disabled while the timer vectors run, so no time-out lands among them.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int PS_W   = 3;
  localparam int MODE_W = PS_W + 3;

  typedef struct packed {
    logic            src;    // 1: external pin, 0: cycle enable
    logic            edge_f; // 1: falling edges, 0: rising edges
    logic            owner;  // 1: prescaler serves watchdog
    logic [PS_W-1:0] ratio;  // division select
  } tw_mode_t;

  localparam logic [MODE_W-1:0] MODE_RST = '1;
endpackage

// File: rtl/tw_mode_reg.sv
module tw_mode_reg
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MODE_W-1:0] wdata,
  output tw_mode_t          mode,
  output logic              owner_chg
);
  tw_mode_t nxt;
  assign nxt       = tw_mode_t'(wdata);
  assign owner_chg = we && (nxt.owner != mode.owner);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= tw_mode_t'(MODE_RST);
    else if (we) mode <= nxt;
  end
endmodule

// File: rtl/tw_edge_src.sv
module tw_edge_src (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic use_pin,
  input  logic falling,
  input  logic cyc_en,
  output logic src_ev
);
  logic pin_q;
  logic rise, fall, pin_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin;
  end

  assign rise   = pin & ~pin_q;
  assign fall   = ~pin & pin_q;
  assign pin_ev = falling ? fall : rise;
  assign src_ev = use_pin ? pin_ev : cyc_en;
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int PRE_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_ev,
  input  logic [SEL_W-1:0] ratio,
  input  logic             extra_stage,
  output logic             out_ev
);
  localparam int K_W = SEL_W + 1;

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] mask;
  logic [K_W-1:0]   k;

  // number of low count bits that must all be set before a pass-through
  assign k = {1'b0, ratio} + {{SEL_W{1'b0}}, extra_stage};

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (k > K_W'(i));
  end

  assign out_ev = in_ev && ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (in_ev) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tw_wrap_cnt.sv
module tw_wrap_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (ld) begin
        q <= ld_val;
      end else if (inc) begin
        q    <= q + 1'b1;
        wrap <= (q == '1);
      end
    end
  end
endmodule

// File: rtl/tw_timer_wdt.sv
module tw_timer_wdt
  import tw_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 8,
  parameter int WDT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              ext_pin,
  input  logic              wdt_tick,
  input  logic              wdt_en,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              wdt_clr,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              cnt_ovf,
  output logic              wdt_timeout
);
  tw_mode_t         mode_q;
  logic             owner_chg;
  logic             src_ev;
  logic             pre_in, pre_out, pre_clr;
  logic             tmr_inc, wdt_inc, wdt_ev_raw;
  logic [WDT_W-1:0] wdt_q;

  tw_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .we(mode_we), .wdata(mode_wdata),
    .mode(mode_q), .owner_chg(owner_chg)
  );

  tw_edge_src u_src (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .use_pin(mode_q.src),
    .falling(mode_q.edge_f), .cyc_en(cyc_en), .src_ev(src_ev)
  );

  assign wdt_ev_raw = wdt_en & wdt_tick;
  assign pre_in     = mode_q.owner ? wdt_ev_raw : src_ev;
  assign pre_clr    = cnt_we | owner_chg | (wdt_clr & mode_q.owner);

  tw_prescaler #(.PRE_W(PRE_W), .SEL_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(pre_clr), .in_ev(pre_in),
    .ratio(mode_q.ratio), .extra_stage(~mode_q.owner), .out_ev(pre_out)
  );

  assign tmr_inc = mode_q.owner ? src_ev : pre_out;
  assign wdt_inc = mode_q.owner ? pre_out : wdt_ev_raw;

  tw_wrap_cnt #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .ld(cnt_we), .ld_val(cnt_wdata),
    .inc(tmr_inc), .q(cnt_q), .wrap(cnt_ovf)
  );

  tw_wrap_cnt #(.W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_n), .ld(wdt_clr), .ld_val('0),
    .inc(wdt_inc), .q(wdt_q), .wrap(wdt_timeout)
  );
endmodule

// File: rtl/tw_timer_wdt_chk.sv
module tw_timer_wdt_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_en,
  input logic             src_sel,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cnt_ovf,
  input logic             wdt_en,
  input logic             wdt_clr,
  input logic             wdt_timeout
);
  p_ovf_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ovf |-> cnt_q == '0);

  p_ovf_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ovf |=> !cnt_ovf);

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(cnt_wdata));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (cnt_q == $past(cnt_q)) ||
                (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  p_int_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_sel && !cyc_en && !cnt_we) |=> $stable(cnt_q));

  p_wdt_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> !wdt_timeout);

  p_wdt_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_timeout);
endmodule

bind tw_timer_wdt tw_timer_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .src_sel(mode_q.src),
  .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .cnt_ovf(cnt_ovf),
  .wdt_en(wdt_en), .wdt_clr(wdt_clr), .wdt_timeout(wdt_timeout)
);

// File: tb/tw_timer_wdt_bench.sv
module tw_timer_wdt_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0, ext_pin = 1'b0, wdt_tick = 1'b0, wdt_en = 1'b0;
  logic       mode_we = 1'b0, cnt_we = 1'b0, wdt_clr = 1'b0;
  logic [5:0] mode_wdata = '0;
  logic [7:0] cnt_wdata = '0;
  logic [7:0] cnt_q;
  logic       cnt_ovf, wdt_timeout;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  tw_timer_wdt u_tw_timer_wdt (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .wdt_tick(wdt_tick), .wdt_en(wdt_en), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .wdt_clr(wdt_clr), .cnt_q(cnt_q), .cnt_ovf(cnt_ovf),
    .wdt_timeout(wdt_timeout)
  );

  // {mode, events, expected count} ; mode = {src, edge, owner, ratio}
  typedef struct packed { logic [5:0] m; logic [15:0] n; logic [7:0] e; } vec_t;
  localparam vec_t VECS [6] = '{
    '{6'b001000, 16'd5,   8'd5},  // R2 undivided
    '{6'b001111, 16'd9,   8'd9},  // R2 ratio ignored when watchdog owns
    '{6'b000000, 16'd7,   8'd3},  // R3 1:2
    '{6'b000010, 16'd20,  8'd2},  // R3 1:8
    '{6'b000011, 16'd47,  8'd2},  // R3 1:16
    '{6'b000111, 16'd600, 8'd2}   // R3 1:256
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [5:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic clr_wdt();
    @(negedge clk); wdt_clr = 1'b1;
    @(negedge clk); wdt_clr = 1'b0;
  endtask

  task automatic cyc(input int n);
    @(negedge clk); cyc_en = 1'b1;
    repeat (n) @(negedge clk);
    cyc_en = 1'b0;
  endtask

  task automatic pin_to(input logic v);
    @(negedge clk); ext_pin = v;
    @(negedge clk);
  endtask

  task automatic ticks(input int n, output int seen);
    seen = 0;
    @(negedge clk); wdt_tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      seen += int'(wdt_timeout);
    end
    wdt_tick = 1'b0;
  endtask

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt after reset", cnt_q, 0);
    chk("R1 ovf after reset", cnt_ovf, 0);
    chk("R1 timeout after reset", wdt_timeout, 0);
    cyc(4);
    chk("R1 reset mode ignores cyc_en", cnt_q, 0);
    pin_to(1'b1);
    chk("R1 reset mode ignores rise", cnt_q, 0);
    pin_to(1'b0);
    chk("R1 reset mode counts fall", cnt_q, 1);

    // vector table: R2 / R3
    foreach (VECS[i]) begin
      wr_mode(VECS[i].m);
      wr_cnt(8'd0);
      cyc(int'(VECS[i].n));
      chk($sformatf("R2/R3 vector %0d", i), cnt_q, int'(VECS[i].e));
    end

    // R4 rising edges
    wr_mode(6'b101000); wr_cnt(8'd0);
    pin_to(1'b1); chk("R4 rise counted", cnt_q, 1);
    pin_to(1'b0); chk("R4 fall ignored", cnt_q, 1);
    pin_to(1'b1); chk("R4 second rise", cnt_q, 2);
    // R4 falling edges
    wr_mode(6'b111000); wr_cnt(8'd0);
    pin_to(1'b0); chk("R4 fall counted", cnt_q, 1);
    pin_to(1'b1); chk("R4 rise ignored", cnt_q, 1);
    // R5 src=1 ignores cyc_en
    cyc(5); chk("R5 cyc_en ignored on pin source", cnt_q, 1);
    // R5 src=0 ignores pin
    wr_mode(6'b001000); wr_cnt(8'd0);
    pin_to(1'b0); pin_to(1'b1); pin_to(1'b0);
    chk("R5 pin ignored on cycle source", cnt_q, 0);

    // R6 overflow
    wr_cnt(8'hFE);
    cyc(1); chk("R6 reach FF", cnt_q, 255);
    chk("R6 no ovf at FF", cnt_ovf, 0);
    cyc(1); chk("R6 wrap to zero", cnt_q, 0);
    chk("R6 ovf pulse", cnt_ovf, 1);
    @(negedge clk); chk("R6 ovf one cycle", cnt_ovf, 0);

    // R7 write priority and prescaler clear
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = 8'h40; cyc_en = 1'b1;
    @(negedge clk); cnt_we = 1'b0; cyc_en = 1'b0;
    chk("R7 write beats increment", cnt_q, 64);
    wr_mode(6'b000001); wr_cnt(8'd0);
    cyc(3); wr_cnt(8'd10);
    cyc(3); chk("R7 prescaler cleared by write", cnt_q, 10);
    cyc(1); chk("R7 count after 4 events", cnt_q, 11);

    // R11 owner change clears prescaler
    wr_cnt(8'd0);
    cyc(3); wr_mode(6'b001001); wr_mode(6'b000001);
    cyc(3); chk("R11 prescaler cleared by owner change", cnt_q, 0);
    cyc(1); chk("R11 count after 4 events", cnt_q, 1);

    // R8 watchdog
    @(negedge clk); wdt_en = 1'b1;
    wr_mode(6'b001000); clr_wdt();
    ticks(255, s); chk("R8 no timeout at 255 ratio1", s, 0);
    ticks(1, s);   chk("R8 timeout at 256 ratio1", s, 1);
    wr_mode(6'b001001); clr_wdt();
    ticks(511, s); chk("R8 no timeout at 511 ratio2", s, 0);
    ticks(1, s);   chk("R8 timeout at 512 ratio2", s, 1);
    wr_mode(6'b000111); clr_wdt();
    ticks(255, s); chk("R8 no timeout 255 timer owns", s, 0);
    ticks(1, s);   chk("R8 timeout 256 timer owns", s, 1);

    // R9 clear restarts
    wr_mode(6'b001001); clr_wdt();
    ticks(201, s); clr_wdt();
    ticks(511, s); chk("R9 restart after clear", s, 0);
    ticks(1, s);   chk("R9 timeout after full period", s, 1);

    // R10 disabled watchdog
    clr_wdt();
    @(negedge clk); wdt_en = 1'b0;
    ticks(700, s); chk("R10 no timeout while disabled", s, 0);
    @(negedge clk); wdt_en = 1'b1;
    ticks(1, s);   chk("R10 count held while disabled", s, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule